// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block watches for software liveness. While enabled, it counts system clock cycles. A 2-bit select chooses one of four power-of-two timeout intervals. When the interval runs out, the block sets a sticky timeout flag. The interrupt output follows that flag only while the interrupt enable is high.

The same expiry opens a fixed grace window, 512 cycles by default. Software can restart the watchdog at any point up to the last cycle of that window. A restart zeroes both counters and cancels the window. If no restart arrives in time, the block emits a one-cycle system reset pulse and then begins a fresh interval from zero.

Dropping the enable holds the block quiet. Both counters stay at zero, the flag stays clear and neither output is driven high. The interval lengths come from two parameters, a base exponent and a per-step exponent increment. The defaults give 2^15, 2^18, 2^21 and 2^24 cycles. At 12 MHz that is roughly 2.7 ms, 21.9 ms, 174.7 ms and 1.4 s, with a reset delay near 42.7 µs.

Top module: `wdt_escalate`

## Requirements
- R1: While rst_n is low, wd_irq and wd_rst are both low.
- R2: With wd_en high and no restart, the timeout flag is set on the clock edge that completes 2^(BASE_EXP + EXP_STEP*int_sel) counted cycles after counting starts from zero. With the defaults, int_sel values 0, 1, 2 and 3 give 2^15, 2^18, 2^21 and 2^24 cycles.
- R3: wd_irq is high exactly when the timeout flag is set, int_en is high and wd_en is high.
- R4: The timeout flag is set at expiry even when int_en is low, and it stays set through later cycles until flag_clr is applied. Raising int_en afterwards makes wd_irq high at once.
- R5: If no restart arrives, wd_rst pulses on the edge exactly WIN_CYC cycles (default 512) after the timeout edge, for every interval select.
- R6: The wd_rst pulse lasts one cycle. Afterwards both counters are back at zero, so the next timeout takes a full interval.
- R7: A restart sampled on any edge of the grace window, including the edge on which the reset would fire, prevents the reset pulse.
- R8: A restart during the interval zeroes the count, so the next timeout comes a full interval after the restart. flag_clr clears the flag, but an expiry on the same edge takes priority.
- R9: While wd_en is low, the counters are held at zero, the flag is cleared and both outputs stay low. After wd_en rises again, a full interval is counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_en | input | 1 | Watchdog enable |
| int_sel | input | 2 | Timeout interval select |
| int_en | input | 1 | Interrupt enable |
| restart | input | 1 | Restart strobe, one cycle |
| flag_clr | input | 1 | Clears the timeout flag |
| wd_irq | output | 1 | Interrupt request, level |
| wd_rst | output | 1 | System reset request, one-cycle pulse |

## Verification
The main function is tried under four patterns, with a behavioural model compared against both outputs on every cycle.

- **Undisturbed expiry for each select.** This separates the four interval lengths from each other and from the fixed window length.
- **Restart midway through an interval and on the final window edge.** This shows whether a restart really zeroes the count and whether it wins the race against the reset.
- **Expiry with the interrupt disabled, followed by enabling it.** This separates the sticky flag from the gated interrupt.
- **A stretch with the enable low.** This shows that the counters restart from zero rather than resuming.

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
  parameter int BASE_EXP = 15,
  parameter int EXP_STEP = 3,
  parameter int WIN_CYC  = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_en,
  input  logic [1:0] int_sel,
  input  logic       int_en,
  input  logic       restart,
  input  logic       flag_clr,
  output logic       wd_irq,
  output logic       wd_rst
);
  localparam int CW = BASE_EXP + 3 * EXP_STEP;
  localparam int WW = $clog2(WIN_CYC);

  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;
  logic          armed, tmo_flag, rst_q;
  logic [CW:0]   span;
  logic [CW-1:0] lim_m1;
  logic          expire, wlast;

  assign span   = (CW+1)'(1) << (BASE_EXP + EXP_STEP * int'(int_sel));
  assign lim_m1 = CW'(span - (CW+1)'(1));
  assign expire = !armed && (cnt >= lim_m1);
  assign wlast  = armed && (wcnt == WW'(WIN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; wcnt <= '0; armed <= 1'b0; rst_q <= 1'b0;
    end else if (!wd_en) begin
      cnt <= '0; wcnt <= '0; armed <= 1'b0; rst_q <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (restart) begin
        cnt <= '0; wcnt <= '0; armed <= 1'b0;
      end else if (armed) begin
        if (wlast) begin
          rst_q <= 1'b1; armed <= 1'b0; wcnt <= '0; cnt <= '0;
        end else begin
          wcnt <= wcnt + WW'(1);
        end
      end else if (expire) begin
        armed <= 1'b1; cnt <= '0; wcnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tmo_flag <= 1'b0;
    else if (!wd_en)             tmo_flag <= 1'b0;
    else if (expire && !restart) tmo_flag <= 1'b1;
    else if (flag_clr)           tmo_flag <= 1'b0;
  end

  assign wd_irq = tmo_flag & int_en & wd_en;
  assign wd_rst = rst_q;

  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);
  assert_rst_from_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> ($past(armed) && !armed));
  assert_window_after_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> tmo_flag);
  assert_restart_no_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && wd_en) |=> !wd_rst);
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && tmo_flag && !flag_clr) |=> tmo_flag);
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> (!wd_rst && !armed && cnt == '0 && !tmo_flag));
endmodule

// File: tb/tb_wdt_escalate.sv
module tb_wdt_escalate;
  localparam int BASE = 6;
  localparam int STEP = 1;
  localparam int WIN  = 512;

  logic clk = 0, rst_n = 0, wd_en = 0, int_en = 0, restart = 0, flag_clr = 0;
  logic [1:0] int_sel = 0;
  logic wd_irq, wd_rst;

  wdt_escalate #(.BASE_EXP(BASE), .EXP_STEP(STEP), .WIN_CYC(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .int_sel(int_sel), .int_en(int_en),
    .restart(restart), .flag_clr(flag_clr), .wd_irq(wd_irq), .wd_rst(wd_rst));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, n = 0, rst_seen = 0;
  int m_cnt = 0, m_w = 0, m_lim = 0;
  bit m_armed = 0, m_flag = 0, m_rst = 0, m_set = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n || !wd_en) begin
      m_cnt = 0; m_w = 0; m_armed = 0; m_flag = 0; m_rst = 0;
    end else begin
      m_lim = 1 << (BASE + STEP * int'(int_sel));
      m_set = 0; m_rst = 0;
      if (restart) begin
        m_cnt = 0; m_w = 0; m_armed = 0;
      end else if (m_armed) begin
        if (m_w == WIN - 1) begin m_rst = 1; m_armed = 0; m_w = 0; m_cnt = 0; end
        else m_w++;
      end else if (m_cnt >= m_lim - 1) begin
        m_armed = 1; m_w = 0; m_cnt = 0; m_set = 1;
      end else m_cnt++;
      if (m_set) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 wd_irq vs model", int'(wd_irq), int'(m_flag && int_en && wd_en));
      chk("R5 wd_rst vs model", int'(wd_rst), int'(m_rst));
      if (wd_rst) rst_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R1 watchdog expired: actual %0d expected 0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int k);
    repeat (k) begin @(posedge clk); #3; end
  endtask

  task automatic wait_irq();
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!wd_irq && n < 5000);
  endtask

  task automatic wait_rst();
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!wd_rst && n < 5000);
  endtask

  task automatic restart_pulse();
    restart = 1; flag_clr = 1;
    step(1);
    restart = 0; flag_clr = 0;
  endtask

  initial begin
    step(3);
    chk("R1 irq in reset", int'(wd_irq), 0);
    chk("R1 rst in reset", int'(wd_rst), 0);
    rst_n = 1;
    step(1);

    // undisturbed expiry, then reset
    int_sel = 0; int_en = 1; wd_en = 1;
    wait_irq();
    chk("R2 sel0 interval", n, 64);
    wait_rst();
    chk("R5 window length sel0", n, WIN);
    @(negedge clk);
    chk("R6 pulse one cycle", int'(wd_rst), 0);
    @(posedge clk); #3;
    flag_clr = 1; step(1); flag_clr = 0;
    @(negedge clk);
    chk("R8 flag cleared", int'(wd_irq), 0);

    // each remaining select: interval, then restart inside window
    for (int s = 1; s < 4; s++) begin
      @(posedge clk); #3;
      int_sel = 2'(s);
      restart_pulse();
      wait_irq();
      chk("R2 interval per select", n, 1 << (BASE + STEP * s));
      rst_seen = 0;
      step(100);
      restart = 1; step(1); restart = 0;
      step(600);
      chk("R7 no reset after restart", rst_seen, 0);
    end

    // reset on select 3 still after WIN cycles
    restart_pulse();
    wait_irq();
    wait_rst();
    chk("R5 window length sel3", n, WIN);

    // restart on the very last window edge
    @(posedge clk); #3;
    int_sel = 0;
    restart_pulse();
    wait_irq();
    repeat (WIN - 1) @(posedge clk);
    #3; restart = 1; step(1); restart = 0;
    rst_seen = 0;
    step(20);
    chk("R7 last-edge restart", rst_seen, 0);

    // mid-interval restart
    restart_pulse();
    step(40);
    restart = 1; step(1); restart = 0;
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!wd_irq && n < 5000);
    chk("R8 interval after restart", n, 64);

    // expiry with interrupt disabled
    @(posedge clk); #3;
    int_en = 0;
    restart_pulse();
    step(80);
    @(negedge clk);
    chk("R4 irq masked", int'(wd_irq), 0);
    @(posedge clk); #3;
    int_en = 1;
    @(negedge clk);
    chk("R4 flag kept while masked", int'(wd_irq), 1);

    // enable low
    @(posedge clk); #3;
    wd_en = 0;
    rst_seen = 0;
    step(700);
    @(negedge clk);
    chk("R9 irq low when disabled", int'(wd_irq), 0);
    chk("R9 no reset when disabled", rst_seen, 0);
    @(posedge clk); #3;
    wd_en = 1;
    wait_irq();
    chk("R9 count from zero", n, 64);

    step(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule